// File: doc/BRIEF.md
# Low-Power Escape Command Line Encoder

This block sends display-configuration bytes over the first data lane of a serial display link. It does not use the high-speed path. Instead it drives the two single-ended low-power wires of the lane, called the P wire and the N wire. A command source, such as a ROM sequencer or a host, first asks the block to enter escape mode. It then hands over one byte at a time and finally asks the block to leave escape mode. Each of the three actions is a single-cycle strobe. The block drops `ready` while it is busy and raises it again when it can accept the next strobe.

Entry into escape mode is a fixed five-step pattern on the wire pair. Each data bit becomes a mark state, in which exactly one wire is high, followed by a spacer state, in which both wires are low. A byte therefore takes sixteen clocks. Leaving escape mode passes through one intermediate state before the pair returns to the idle state with both wires high.

The wire states, the `ready` flag and the internal mode all change on the rising edge of `clk` after the strobe that starts them. Strobes that arrive when they cannot be acted on are dropped.

Top module: `esc_cmd_encoder`

## Requirements
- R1: While reset is asserted and after it is released, `line_p`=1, `line_n`=1 and `ready`=1.
- R2: When `esc_req` is sampled high in the idle state, the pair shows (P,N) = 11, 10, 00, 01, 00 on the five clocks that follow, with `ready` low. On the next clock `ready` returns high and the pair holds 00.
- R3: When `byte_load` is sampled high in escape mode with `ready` high, `cmd_byte` is captured and sent LSB first. A bit of 1 appears as (P,N)=10 and a bit of 0 as (P,N)=01. Each mark is followed by one clock of 00.
- R4: `ready` stays low for exactly the 16 clocks of a byte. On the following clock `ready` is high and the pair shows 00.
- R5: When `stop_req` is sampled high in escape mode with `ready` high, the pair shows 10 and then 11. `ready` is low for the 10 clock and high from the 11 clock onward. The block is idle again afterwards, and a new `esc_req` is needed before bytes are accepted.
- R6: If `byte_load` and `stop_req` are sampled high together in escape mode, the byte is sent and the stop request is dropped.
- R7: `byte_load` and `stop_req` sampled in the idle state have no effect: the pair stays 11 and `ready` stays 1.
- R8: Any strobe sampled while `ready` is low has no effect on the sequence in progress. This holds even when `cmd_byte` changes at the same time.
- R9: `esc_req` sampled in escape mode has no effect: the pair stays 00 and `ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_byte | input | DATA_W | Command byte, captured on `byte_load` |
| esc_req | input | 1 | Strobe: enter escape mode |
| byte_load | input | 1 | Strobe: capture and send `cmd_byte` |
| stop_req | input | 1 | Strobe: leave escape mode |
| ready | output | 1 | High when a strobe will be accepted |
| line_p | output | 1 | P wire of the low-power pair |
| line_n | output | 1 | N wire of the low-power pair |

## Verification
The hardest cases to reach are strobes that collide with the block's own busy windows. One is a stop request arriving in the same cycle as a byte load. Another is a request that arrives on every cycle of a byte or of the entry pattern while `ready` is low, together with a changing data bus. The stimulus lets the driver hold every strobe high throughout those windows and flip `cmd_byte` at the same time. The expected wire sequence stays the one set by the originally captured byte. The bench also returns to idle with a stop and then proves that a byte strobe is dropped until a fresh entry.

// File: rtl/esc_enc_pkg.sv
package esc_enc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_ESC,
        ST_SHIFT,
        ST_STOP
    } esc_state_e;

    typedef struct packed {
        logic p;
        logic n;
    } lp_pair_t;

    localparam int ENTRY_STEPS = 5;

    function automatic lp_pair_t mk_pair(input logic p, input logic n);
        lp_pair_t r;
        r.p = p;
        r.n = n;
        return r;
    endfunction

    // entry pattern: 11, 10, 00, 01, 00
    function automatic lp_pair_t entry_step(input int unsigned idx);
        lp_pair_t r;
        case (idx)
            0:       r = mk_pair(1'b1, 1'b1);
            1:       r = mk_pair(1'b1, 1'b0);
            2:       r = mk_pair(1'b0, 1'b0);
            3:       r = mk_pair(1'b0, 1'b1);
            default: r = mk_pair(1'b0, 1'b0);
        endcase
        return r;
    endfunction

    // mark state for one data bit: 1 -> 10, 0 -> 01
    function automatic lp_pair_t bit_mark(input logic b);
        return b ? mk_pair(1'b1, 1'b0) : mk_pair(1'b0, 1'b1);
    endfunction

endpackage

// File: rtl/esc_shift_reg.sv
module esc_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              advance,
    output logic              cur_bit
);

    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load) begin
            data_d = load_val;
        end else if (advance) begin
            data_d = data_q >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign cur_bit = data_q[0];

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_bit == $past(load_val[0])))                      // R3
        else $error("shift register did not capture the LSB");

    AST_ADV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (data_q[DATA_W-1] == 1'b0))              // R3
        else $error("shift register did not shift in a zero");

endmodule

// File: rtl/esc_step_counter.sv
module esc_step_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(1);
        end else if (run) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == CNT_W'(1)))                                 // R2
        else $error("step counter did not restart at one");

endmodule

// File: rtl/esc_line_ctrl.sv
module esc_line_ctrl
    import esc_enc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             esc_req,
    input  logic             byte_load,
    input  logic             stop_req,
    input  logic             load_lsb,
    input  logic             cur_bit,
    input  logic [CNT_W-1:0] count,
    output logic             sh_load,
    output logic             sh_adv,
    output logic             cnt_start,
    output logic             cnt_run,
    output logic             ready,
    output logic             line_p,
    output logic             line_n
);

    localparam int SYMS = 2 * DATA_W;

    typedef struct packed {
        esc_state_e st;
        lp_pair_t   line;
        logic       rdy;
    } ctrl_regs_t;

    ctrl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d    = regs_q;
        sh_load   = 1'b0;
        sh_adv    = 1'b0;
        cnt_start = 1'b0;
        cnt_run   = 1'b0;
        case (regs_q.st)
            ST_IDLE: begin
                if (esc_req) begin
                    regs_d.st   = ST_ENTRY;
                    regs_d.line = entry_step(0);
                    regs_d.rdy  = 1'b0;
                    cnt_start   = 1'b1;
                end
            end
            ST_ENTRY: begin
                if (count == CNT_W'(ENTRY_STEPS)) begin
                    regs_d.st   = ST_ESC;
                    regs_d.line = mk_pair(1'b0, 1'b0);
                    regs_d.rdy  = 1'b1;
                end else begin
                    regs_d.line = entry_step(int'(count));
                    cnt_run     = 1'b1;
                end
            end
            ST_ESC: begin
                if (byte_load) begin
                    regs_d.st   = ST_SHIFT;
                    regs_d.line = bit_mark(load_lsb);
                    regs_d.rdy  = 1'b0;
                    sh_load     = 1'b1;
                    cnt_start   = 1'b1;
                end else if (stop_req) begin
                    regs_d.st   = ST_STOP;
                    regs_d.line = mk_pair(1'b1, 1'b0);
                    regs_d.rdy  = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (count == CNT_W'(SYMS)) begin
                    regs_d.st   = ST_ESC;
                    regs_d.line = mk_pair(1'b0, 1'b0);
                    regs_d.rdy  = 1'b1;
                end else if (count[0]) begin
                    regs_d.line = mk_pair(1'b0, 1'b0);
                    sh_adv      = 1'b1;
                    cnt_run     = 1'b1;
                end else begin
                    regs_d.line = bit_mark(cur_bit);
                    cnt_run     = 1'b1;
                end
            end
            ST_STOP: begin
                regs_d.st   = ST_IDLE;
                regs_d.line = mk_pair(1'b1, 1'b1);
                regs_d.rdy  = 1'b1;
            end
            default: begin
                regs_d.st   = ST_IDLE;
                regs_d.line = mk_pair(1'b1, 1'b1);
                regs_d.rdy  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st   <= ST_IDLE;
            regs_q.line <= mk_pair(1'b1, 1'b1);
            regs_q.rdy  <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ready  = regs_q.rdy;
    assign line_p = regs_q.line.p;
    assign line_n = regs_q.line.n;

    AST_ENTRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_IDLE && esc_req) |=> (line_p && line_n && !ready)) // R2
        else $error("entry did not begin with 11 and ready low");

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_IDLE && !esc_req && (byte_load || stop_req))
        |=> (line_p && line_n && ready))                                 // R7
        else $error("strobe in idle changed the lines");

    AST_STOP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_ESC && stop_req && !byte_load)
        |=> (line_p && !line_n && !ready) ##1 (line_p && line_n && ready)) // R5
        else $error("stop sequence wrong");

    AST_MARK_SPACER: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_SHIFT && (line_p ^ line_n)) |=> (!line_p && !line_n)) // R3
        else $error("mark not followed by spacer");

    AST_SHIFT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_SHIFT) |-> (!ready && !(line_p && line_n)))     // R4
        else $error("ready high or idle state during a byte");

    AST_ESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_ESC && !byte_load && !stop_req)
        |=> ($stable(line_p) && $stable(line_n) && ready))               // R9
        else $error("escape mode did not hold");

endmodule

// File: rtl/esc_cmd_encoder.sv
module esc_cmd_encoder
    import esc_enc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic              esc_req,
    input  logic              byte_load,
    input  logic              stop_req,
    output logic              ready,
    output logic              line_p,
    output logic              line_n
);

    localparam int SPAN  = (2 * DATA_W > ENTRY_STEPS) ? 2 * DATA_W : ENTRY_STEPS;
    localparam int CNT_W = $clog2(SPAN + 1);

    logic             sh_load;
    logic             sh_adv;
    logic             cur_bit;
    logic             cnt_start;
    logic             cnt_run;
    logic [CNT_W-1:0] count;

    esc_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (cmd_byte),
        .advance  (sh_adv),
        .cur_bit  (cur_bit)
    );

    esc_step_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cnt_start),
        .run   (cnt_run),
        .count (count)
    );

    esc_line_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .esc_req   (esc_req),
        .byte_load (byte_load),
        .stop_req  (stop_req),
        .load_lsb  (cmd_byte[0]),
        .cur_bit   (cur_bit),
        .count     (count),
        .sh_load   (sh_load),
        .sh_adv    (sh_adv),
        .cnt_start (cnt_start),
        .cnt_run   (cnt_run),
        .ready     (ready),
        .line_p    (line_p),
        .line_n    (line_n)
    );

endmodule

// File: tb/esc_cmd_encoder_test.sv
`timescale 1ns/1ps
module esc_cmd_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       esc_req = 1'b0;
    logic       byte_load = 1'b0;
    logic       stop_req = 1'b0;
    logic       ready;
    logic       line_p;
    logic       line_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    esc_cmd_encoder #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .esc_req(esc_req),
        .byte_load(byte_load), .stop_req(stop_req), .ready(ready),
        .line_p(line_p), .line_n(line_n)
    );

    task automatic compare(input logic [2:0] e, input string tag);
        n_cmp++;
        if ({line_p, line_n, ready} !== e) begin
            n_bad++;
            $display("FAIL %s: got p=%0b n=%0b rdy=%0b expected p=%0b n=%0b rdy=%0b",
                     tag, line_p, line_n, ready, e[2], e[1], e[0]);
        end
    endtask

    // monitor: pops one expected item per clock, samples after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // driver: one call = one clock; expected outputs after that edge
    task automatic cyc(input logic e, input logic l, input logic s, input logic [7:0] b,
                       input logic [2:0] ex, input string tag);
        @(negedge clk);
        esc_req = e; byte_load = l; stop_req = s; cmd_byte = b;
        exp_q.push_back(ex);
        tag_q.push_back(tag);
    endtask

    task automatic entry(input logic noisy, input string tag);
        cyc(1, 0, 0, 8'h00, 3'b110, tag);
        cyc(noisy, noisy, noisy, 8'h5A, 3'b100, tag);
        cyc(noisy, noisy, noisy, 8'hA5, 3'b000, tag);
        cyc(noisy, noisy, noisy, 8'h5A, 3'b010, tag);
        cyc(noisy, noisy, noisy, 8'hA5, 3'b000, tag);
        cyc(0, 0, 0, 8'h00, 3'b001, tag);
    endtask

    task automatic send(input logic [7:0] b, input logic with_stop, input logic noisy,
                        input string tag);
        cyc(0, 1, with_stop, b, b[0] ? 3'b100 : 3'b010, tag);
        for (int i = 1; i < 16; i++) begin
            if (i % 2 == 1)
                cyc(noisy, noisy, noisy, ~b, 3'b000, tag);
            else
                cyc(noisy, noisy, noisy, ~b, b[i/2] ? 3'b100 : 3'b010, tag);
        end
        cyc(0, 0, 0, 8'h00, 3'b001, tag);
    endtask

    task automatic stop_seq(input string tag);
        cyc(0, 0, 1, 8'h00, 3'b100, tag);
        cyc(0, 0, 0, 8'h00, 3'b111, tag);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(3'b111, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(3'b111, "R1 after reset");

        cyc(0, 1, 0, 8'hFF, 3'b111, "R7 load in idle");
        cyc(0, 0, 1, 8'h00, 3'b111, "R7 stop in idle");
        cyc(0, 1, 1, 8'h0F, 3'b111, "R7 both in idle");

        entry(0, "R2 entry");
        cyc(1, 0, 0, 8'h00, 3'b001, "R9 esc in escape");
        cyc(0, 0, 0, 8'h00, 3'b001, "R9 hold");

        send(8'hA5, 0, 0, "R3 R4 byte A5");
        send(8'h00, 0, 1, "R8 noisy byte 00");
        send(8'hFF, 0, 0, "R3 byte FF");
        stop_seq("R5 stop");
        cyc(0, 1, 0, 8'h81, 3'b111, "R5 load after stop ignored");

        entry(1, "R8 noisy entry");
        send(8'h3C, 1, 0, "R6 load with stop");
        cyc(0, 0, 0, 8'h00, 3'b001, "R6 still in escape");
        send(8'h01, 0, 0, "R3 byte 01");
        stop_seq("R5 final stop");
        cyc(0, 0, 0, 8'h00, 3'b111, "R1 idle at end");

        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule